// File: doc/BRIEF.md
# GF(2^m) Multiplier Built from Two Squaring Passes

This block multiplies two field elements of GF(2^M) in polynomial basis without any multiplier array. The multiplier operand B is split into its even-indexed and odd-indexed bits, giving two half-length words B1 and B2. The product then follows from the identity A·B = A·B1(α)² + (A·α)·B2(α)² mod P. A single sequential core that evaluates A·X² mod P is run twice. The first pass uses (A, B1), and its result is parked in a holding register. The second pass uses (A·α mod P, B2). The two results are XORed to give the product.

Operands enter on a valid/ready handshake. One operation runs at a time. `in_ready` is high only while the block is idle, so a source that keeps `in_valid` high simply waits. The result leaves on a valid/ready handshake. `out_valid` stays high and `out_d` stays frozen until the sink raises `out_ready`, and no new operands are taken until that happens. The reduction polynomial is supplied with every operation as its M low coefficients; the x^M term is implied.

Top module: `gf2m_sqmul`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `out_d` is 0.
- R2: `out_d` equals A·B mod P. Bit j of `in_a`, `in_b` and `out_d` is the coefficient of α^j. Bit j of `in_poly` is p_j of P(x) = x^M + p_(M-1)x^(M-1) + … + p_0.
- R3: The squaring core takes a word X of H = ceil(M/2) bits and returns A·X(α)² mod P. It consumes X most significant bit first, one bit per cycle, using S ← S·α² + A·x_i from S = 0.
- R4: Pass one feeds the core A and B1 = (b_0, b_2, b_4, …) packed from bit 0 upward. Pass two feeds it A' = A·α mod P and B2 = (b_1, b_3, …) packed the same way. For odd M the top bit of B2 is zero. The output is the XOR of the two pass results.
- R5: Operands are taken only on a cycle with `in_valid` and `in_ready` both high. While an operation is in flight `in_ready` is 0, and any values on `in_a`, `in_b`, `in_poly` or `in_valid` have no effect on the result.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_d` does not change. The cycle with both high ends the operation and returns `in_ready` to 1.
- R7: `out_valid` is first seen high 2H+4 clock edges after the accepting edge.
- R8: Corner operands give field results: A = 0 gives 0, B = 1 gives A, and A = B gives A² mod P.
- R9: The product α^(M-1)·α reduces through P to the value `in_poly`. This exercises the shift-with-reduction that forms A'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block idle, operands will be taken |
| in_a | input | M | Multiplicand A |
| in_b | input | M | Multiplier B |
| in_poly | input | M | Low coefficients p_0..p_(M-1) of P(x) |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Sink takes the product |
| out_d | output | M | Product A·B mod P |

## Verification
The hardest case to reach from the ports is an operation whose result depends on the second pass reducing A·α. That second-pass reduction only happens when A has its top bit set. The vector table therefore includes several operands with bit M-1 high, plus the single-term product α^(M-1)·α, whose answer is exactly the polynomial. A separate directed case sends fresh operands with `in_valid` held high during both passes. It then confirms that the first product comes out unchanged, so the ignore rule is checked at the output.

// File: rtl/gfsq_pkg.sv
package gfsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/gfsq_alpha.sv
// Multiply a field element by alpha and reduce with the implied x^M term.
module gfsq_alpha #(
  parameter int M = 8
) (
  input  logic [M-1:0] in_v,
  input  logic [M-1:0] poly,
  output logic [M-1:0] out_v
);
  genvar j;
  generate
    for (j = 0; j < M; j++) begin : g_bit
      if (j == 0) begin : g_lo
        assign out_v[j] = in_v[M-1] & poly[j];
      end else begin : g_hi
        assign out_v[j] = (in_v[M-1] & poly[j]) ^ in_v[j-1];
      end
    end
  endgenerate
endmodule

// File: rtl/gfsq_split.sv
// Even/odd bit separation of the multiplier into two half-length words.
module gfsq_split #(
  parameter int M = 8,
  parameter int H = (M + 1) / 2
) (
  input  logic [M-1:0] b,
  output logic [H-1:0] even_w,
  output logic [H-1:0] odd_w
);
  genvar i;
  generate
    for (i = 0; i < H; i++) begin : g_pair
      assign even_w[i] = b[2*i];
      if (2*i + 1 < M) begin : g_odd
        assign odd_w[i] = b[2*i+1];
      end else begin : g_pad
        assign odd_w[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/gfsq_core.sv
// Sequential A*X^2 mod P, one bit of X per cycle, most significant first.
module gfsq_core #(
  parameter int M = 8,
  parameter int H = (M + 1) / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [H-1:0] x,
  input  logic [M-1:0] poly,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] y
);
  localparam int CW = $clog2(H + 1);

  logic [M-1:0]  acc;
  logic [H-1:0]  xsh;
  logic [CW-1:0] cnt;
  logic [M-1:0]  t1, t2, nxt;

  gfsq_alpha #(.M(M)) u_sh1 (.in_v(acc), .poly(poly), .out_v(t1));
  gfsq_alpha #(.M(M)) u_sh2 (.in_v(t1),  .poly(poly), .out_v(t2));

  assign nxt = t2 ^ (xsh[H-1] ? a : '0);
  assign y   = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      xsh  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc  <= '0;
        xsh  <= x;
        cnt  <= CW'(H);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= nxt;
        xsh <= xsh << 1;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: a start launches a pass
  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3: completion is reported only once stepping has stopped
  assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/gf2m_sqmul.sv
module gf2m_sqmul
  import gfsq_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  input  logic [M-1:0] in_poly,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_d
);
  localparam int H = (M + 1) / 2;

  seq_state_t   state;
  logic [M-1:0] a_q, b_q, p_q, y1_q, d_q;
  logic         kick;
  logic [H-1:0] b_even, b_odd;
  logic [M-1:0] a_alpha;
  logic [M-1:0] core_a;
  logic [H-1:0] core_x;
  logic         core_busy, core_done;
  logic [M-1:0] core_y;

  gfsq_split #(.M(M), .H(H)) u_split (.b(b_q), .even_w(b_even), .odd_w(b_odd));
  gfsq_alpha #(.M(M)) u_aalpha (.in_v(a_q), .poly(p_q), .out_v(a_alpha));

  // Operand switches: pass two takes A*alpha and the odd bits.
  always_comb begin
    if (state == ST_PASS2) begin
      core_a = a_alpha;
      core_x = b_odd;
    end else begin
      core_a = a_q;
      core_x = b_even;
    end
  end

  gfsq_core #(.M(M), .H(H)) u_core (
    .clk(clk), .rst_n(rst_n), .start(kick), .a(core_a), .x(core_x),
    .poly(p_q), .busy(core_busy), .done(core_done), .y(core_y)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_d     = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      p_q   <= '0;
      y1_q  <= '0;
      d_q   <= '0;
      kick  <= 1'b0;
    end else begin
      kick <= 1'b0;
      unique case (state)
        ST_IDLE: if (in_valid) begin
          a_q   <= in_a;
          b_q   <= in_b;
          p_q   <= in_poly;
          kick  <= 1'b1;
          state <= ST_PASS1;
        end
        ST_PASS1: if (core_done) begin
          y1_q  <= core_y;
          kick  <= 1'b1;
          state <= ST_PASS2;
        end
        ST_PASS2: if (core_done) begin
          d_q   <= y1_q ^ core_y;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: an accepted operation closes the input and starts the core
  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && kick));
  // R4: the core is idle whenever a pass is launched
  assert_kick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !core_busy);
  // R4: end of pass one launches pass two
  assert_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PASS1 && core_done) |=> (state == ST_PASS2 && kick));
  // R6: a stalled result is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_d)));
endmodule

// File: tb/sim_gf2m_sqmul.sv
module sim_gf2m_sqmul;
  localparam int M = 8;
  localparam int H = (M + 1) / 2;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [3*M-1:0] VEC [NV] = '{
    {8'h57, 8'h83, 8'h1B}, {8'hFF, 8'hFF, 8'h1B}, {8'h80, 8'h80, 8'h1B},
    {8'hC3, 8'h5A, 8'h1D}, {8'h01, 8'hA7, 8'h1D}, {8'h9E, 8'h3C, 8'h2B},
    {8'hAA, 8'h55, 8'h1B}, {8'hF0, 8'h0F, 8'h1D}, {8'h13, 8'hE9, 8'h2B},
    {8'h8D, 8'hB6, 8'h1B}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [M-1:0] in_a = '0, in_b = '0, in_poly = '0;
  logic in_ready, out_valid;
  logic [M-1:0] out_d;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf2m_sqmul #(.M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_poly(in_poly), .out_valid(out_valid),
    .out_ready(out_ready), .out_d(out_d)
  );

  function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] p);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ (r[M-1] ? p : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one operation; returns product and edges from accept to out_valid.
  task automatic run_op(input logic [M-1:0] a, b, p, input int hold,
                        output logic [M-1:0] prod, output int lat);
    @(negedge clk);
    in_a = a; in_b = b; in_poly = p; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    prod = out_d;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R6 valid held", 32'(out_valid), 32'd1);
      chk("R6 data held", 32'(out_d), 32'(prod));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 ready returns", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [M-1:0] prod;
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 out_d", 32'(out_d), 32'd0);
    rst_n = 1'b1;

    // R2/R4/R7 table walk
    for (int v = 0; v < NV; v++) begin
      logic [M-1:0] va, vb, vp;
      {va, vb, vp} = VEC[v];
      run_op(va, vb, vp, (v == 3) ? 4 : 0, prod, lat);
      chk("R2 product", 32'(prod), 32'(ref_mul(va, vb, vp)));
      chk("R7 latency", 32'(lat), 32'(2*H + 4));
    end

    // R8 corners
    run_op(8'h00, 8'hB5, 8'h1B, 0, prod, lat);
    chk("R8 A=0", 32'(prod), 32'd0);
    run_op(8'hC9, 8'h01, 8'h1B, 0, prod, lat);
    chk("R8 B=1", 32'(prod), 32'hC9);
    run_op(8'hE7, 8'hE7, 8'h1D, 0, prod, lat);
    chk("R8 A=B", 32'(prod), 32'(ref_mul(8'hE7, 8'hE7, 8'h1D)));

    // R9 alpha^(M-1) * alpha yields the polynomial
    run_op(8'h80, 8'h02, 8'h2B, 0, prod, lat);
    chk("R9 reduce", 32'(prod), 32'h2B);

    // R5 inputs ignored while busy
    @(negedge clk);
    in_a = 8'h57; in_b = 8'h83; in_poly = 8'h1B; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 8'hFF; in_b = 8'hFF; in_poly = 8'h1D;
    for (int k = 0; k < 2*H; k++) begin
      chk("R5 closed", 32'(in_ready), 32'd0);
      @(negedge clk);
      in_a = in_a ^ 8'h3C; in_b = in_b + 8'd7;
    end
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk("R5 result unaffected", 32'(out_d), 32'(ref_mul(8'h57, 8'h83, 8'h1B)));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R5 reopened", 32'(in_ready), 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule